// File: doc/BRIEF.md
# Audio Codec Power Sequencing Controller

This controller sits on the host side of an audio codec and brings its playback path to life in a safe order, then tears it down again in the opposite order. It owns the codec's active-low power-down pin. Every control-register change goes out as a single write over a request/acknowledge port, which a separate serial-bus master is expected to serve. The minimum reset-pin hold and the PLL settling time are both counted in cycles of the controller's own clock. The cycle counts come from parameters, so one netlist works at any reference frequency.

Power-up starts with a request while the controller is idle. The reset pin is held low for a programmable minimum time and then released. The controller then enables the analog reference, PLL, converter core and master-clock output together. It waits out the PLL settling time, turns on both converter channel paths, optionally engages the spatial (3D) effect, and switches on the line-out driver last. The line-out driver is switched only once in each direction, which keeps output pops to a minimum.

Power-down runs the same writes in reverse and finally pulls the reset pin low. The choice of whether the effect stage is used is captured once, when power-up is accepted. Both directions then follow that captured choice.

Top module: `pwrseq_ctrl`

## Requirements
- R1: After reset the controller is idle: `pdn_o` low, `wr_req` low, `busy` low, `done` low.
- R2: `up_req` sampled high while idle starts power-up. `busy` rises in the next cycle. `pdn_o` then stays low for RST_CYC+1 further cycles and rises at the next edge.
- R3: The first write is presented in the same cycle `pdn_o` rises: address 0x10, data 0x0F. Bit 0 is the reference, bit 1 the PLL, bit 2 the converter core and bit 3 the master-clock output.
- R4: After the 0x10 write is acknowledged, `wr_req` stays low for LOCK_CYC+1 cycles. Then the channel write appears: address 0x11, data 0x03 (bit 0 left, bit 1 right).
- R5: `fx_sel` is sampled only when power-up is accepted. If it was 1, the effect write (address 0x12, data 0x01) follows the acknowledged channel write. If it was 0, address 0x12 is not written in either direction. Later changes of `fx_sel` have no effect.
- R6: The line-out write (address 0x13, data 0x01) is the last write of power-up. In the cycle after its acknowledgement, `done` is high and `busy` is low.
- R7: A write request holds `wr_req`, `wr_addr` and `wr_data` stable until an edge where `wr_ack` is high. Each acknowledged edge completes exactly one write. The next write of the sequence, if any, is presented in the following cycle.
- R8: `down_req` sampled while `done` is high starts power-down. The writes are 0x13←0x00, then 0x12←0x00 (only if the effect was selected), then 0x11←0x00, then 0x10←0x00. `pdn_o` falls and the controller returns to idle in the cycle after the last acknowledgement.
- R9: `down_req` is ignored unless `done` is high, and `up_req` is ignored unless the controller is idle.
- R10: `busy` and `done` are never high together, and `wr_req` is high only while `pdn_o` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| up_req | input | 1 | Start power-up (honoured when idle) |
| down_req | input | 1 | Start power-down (honoured when done) |
| fx_sel | input | 1 | Use the spatial effect stage; sampled at power-up acceptance |
| wr_ack | input | 1 | Register write accepted by the bus master |
| pdn_o | output | 1 | Codec power-down pin, active low |
| wr_req | output | 1 | Register write request |
| wr_addr | output | AW | Register address of the pending write |
| wr_data | output | DW | Register data of the pending write |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | Codec path fully powered |

## Verification
The bound checker watches several properties on every cycle. It checks that the reset pin has been low for at least the minimum hold when it rises. It checks that a channel-enable write never comes sooner than the PLL wait after the block-enable acknowledgement, and that the effect write only follows enabled channels. It also checks request stability under back-pressure, that writes only happen with the reset pin high, that power-down opens with the line-out write, and that busy and done are exclusive. Three things can only be shown by the bench's cycle-exact reference model over its scenarios: the full write order in both directions, the exact cycle counts of both waits, and the ignoring of requests and effect-select changes in the wrong state. Recovery from a reset in the middle of a sequence is also left to the bench.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

    typedef enum logic [3:0] {
        PS_IDLE,
        PS_HOLD,
        PS_BLK_ON,
        PS_LOCK,
        PS_CHAN_ON,
        PS_FX_ON,
        PS_LINE_ON,
        PS_READY,
        PS_LINE_OFF,
        PS_FX_OFF,
        PS_CHAN_OFF,
        PS_BLK_OFF
    } pseq_e;

    // Codec register addresses
    localparam int REG_BLOCKS  = 'h10;
    localparam int REG_CHANNEL = 'h11;
    localparam int REG_EFFECT  = 'h12;
    localparam int REG_LINEOUT = 'h13;

    // Register values written during power-up
    localparam int VAL_BLOCKS  = 'h0F; // ref, pll, core, clock out
    localparam int VAL_CHANNEL = 'h03; // left, right
    localparam int VAL_EFFECT  = 'h01; // effect field = 01
    localparam int VAL_LINEOUT = 'h01;

    typedef struct packed {
        pseq_e state;
        logic  pdn;
        logic  fx;
    } seq_t;

endpackage

// File: rtl/pwrseq_timer.sv
module pwrseq_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          zero
);
    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/pwrseq_stepmap.sv
module pwrseq_stepmap
    import pwrseq_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  pseq_e          state,
    output logic           wr_en,
    output logic [AW-1:0]  addr,
    output logic [DW-1:0]  data
);
    always_comb begin
        wr_en = 1'b1;
        addr  = '0;
        data  = '0;
        unique case (state)
            PS_BLK_ON: begin
                addr = AW'(REG_BLOCKS);
                data = DW'(VAL_BLOCKS);
            end
            PS_CHAN_ON: begin
                addr = AW'(REG_CHANNEL);
                data = DW'(VAL_CHANNEL);
            end
            PS_FX_ON: begin
                addr = AW'(REG_EFFECT);
                data = DW'(VAL_EFFECT);
            end
            PS_LINE_ON: begin
                addr = AW'(REG_LINEOUT);
                data = DW'(VAL_LINEOUT);
            end
            PS_LINE_OFF: addr = AW'(REG_LINEOUT);
            PS_FX_OFF:   addr = AW'(REG_EFFECT);
            PS_CHAN_OFF: addr = AW'(REG_CHANNEL);
            PS_BLK_OFF:  addr = AW'(REG_BLOCKS);
            default:     wr_en = 1'b0;
        endcase
    end
endmodule

// File: rtl/pwrseq_ctrl.sv
module pwrseq_ctrl
    import pwrseq_pkg::*;
#(
    parameter int RST_CYC  = 8,
    parameter int LOCK_CYC = 1_000_000,
    parameter int AW       = 8,
    parameter int DW       = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          up_req,
    input  logic          down_req,
    input  logic          fx_sel,
    input  logic          wr_ack,
    output logic          pdn_o,
    output logic          wr_req,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic          busy,
    output logic          done
);
    localparam int MAX_CYC = (RST_CYC > LOCK_CYC) ? RST_CYC : LOCK_CYC;
    localparam int TW      = $clog2(MAX_CYC + 1) + 1;

    seq_t          st_d, st_q;
    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_zero;
    logic          wr_en;
    logic          step_ok;

    pwrseq_timer #(.TW(TW)) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    pwrseq_stepmap #(.AW(AW), .DW(DW)) i_stepmap (
        .state (st_q.state),
        .wr_en (wr_en),
        .addr  (wr_addr),
        .data  (wr_data)
    );

    assign step_ok = wr_en && wr_ack;

    always_comb begin
        st_d     = st_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (st_q.state)
            PS_IDLE: begin
                if (up_req) begin
                    st_d.state = PS_HOLD;
                    st_d.fx    = fx_sel;
                    tmr_load   = 1'b1;
                    tmr_val    = TW'(RST_CYC);
                end
            end
            PS_HOLD: begin
                if (tmr_zero) begin
                    st_d.state = PS_BLK_ON;
                    st_d.pdn   = 1'b1;
                end
            end
            PS_BLK_ON: begin
                if (step_ok) begin
                    st_d.state = PS_LOCK;
                    tmr_load   = 1'b1;
                    tmr_val    = TW'(LOCK_CYC);
                end
            end
            PS_LOCK: begin
                if (tmr_zero) st_d.state = PS_CHAN_ON;
            end
            PS_CHAN_ON: begin
                if (step_ok) st_d.state = st_q.fx ? PS_FX_ON : PS_LINE_ON;
            end
            PS_FX_ON: begin
                if (step_ok) st_d.state = PS_LINE_ON;
            end
            PS_LINE_ON: begin
                if (step_ok) st_d.state = PS_READY;
            end
            PS_READY: begin
                if (down_req) st_d.state = PS_LINE_OFF;
            end
            PS_LINE_OFF: begin
                if (step_ok) st_d.state = st_q.fx ? PS_FX_OFF : PS_CHAN_OFF;
            end
            PS_FX_OFF: begin
                if (step_ok) st_d.state = PS_CHAN_OFF;
            end
            PS_CHAN_OFF: begin
                if (step_ok) st_d.state = PS_BLK_OFF;
            end
            PS_BLK_OFF: begin
                if (step_ok) begin
                    st_d.state = PS_IDLE;
                    st_d.pdn   = 1'b0;
                end
            end
            default: begin
                st_d.state = PS_IDLE;
                st_d.pdn   = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.state <= PS_IDLE;
            st_q.pdn   <= 1'b0;
            st_q.fx    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pdn_o  = st_q.pdn;
    assign wr_req = wr_en;
    assign done   = (st_q.state == PS_READY);
    assign busy   = (st_q.state != PS_IDLE) && (st_q.state != PS_READY);
endmodule

// File: rtl/pwrseq_chk.sv
module pwrseq_chk
    import pwrseq_pkg::*;
#(
    parameter int RST_CYC  = 8,
    parameter int LOCK_CYC = 1_000_000,
    parameter int AW       = 8,
    parameter int DW       = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_ack,
    input logic          pdn_o,
    input logic          wr_req,
    input logic [AW-1:0] wr_addr,
    input logic [DW-1:0] wr_data,
    input logic          busy,
    input logic          done
);
    int   low_cnt;
    int   gap_cnt;
    logic chan_on;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_cnt <= 0;
            gap_cnt <= 0;
            chan_on <= 1'b0;
        end else begin
            if (pdn_o) low_cnt <= 0;
            else if (low_cnt < 32'h7fff_ffff) low_cnt <= low_cnt + 1;

            if (wr_req && wr_ack && wr_addr == AW'(REG_BLOCKS) && wr_data != '0)
                gap_cnt <= 0;
            else if (gap_cnt < 32'h7fff_ffff)
                gap_cnt <= gap_cnt + 1;

            if (wr_req && wr_ack && wr_addr == AW'(REG_CHANNEL))
                chan_on <= (wr_data != '0);
        end
    end

    // R2
    pdn_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pdn_o) |-> low_cnt >= RST_CYC);

    // R4
    lock_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && wr_addr == AW'(REG_CHANNEL) && wr_data != '0) |-> gap_cnt >= LOCK_CYC);

    // R5
    fx_after_chan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && wr_addr == AW'(REG_EFFECT) && wr_data != '0) |-> chan_on);

    // R7
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !wr_ack) |=> (wr_req && $stable(wr_addr) && $stable(wr_data)));

    // R8
    down_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(done) |-> (wr_req && wr_addr == AW'(REG_LINEOUT) && wr_data == '0));

    // R10
    excl_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    // R10
    write_pdn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> pdn_o);
endmodule

bind pwrseq_ctrl pwrseq_chk #(
    .RST_CYC  (RST_CYC),
    .LOCK_CYC (LOCK_CYC),
    .AW       (AW),
    .DW       (DW)
) i_pwrseq_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_ack  (wr_ack),
    .pdn_o   (pdn_o),
    .wr_req  (wr_req),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .busy    (busy),
    .done    (done)
);

// File: tb/test_pwrseq_ctrl.sv
module test_pwrseq_ctrl;
    localparam int RC = 8;
    localparam int LC = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       up_req = 1'b0, down_req = 1'b0, fx_sel = 1'b0, wr_ack = 1'b0;
    logic       pdn_o, wr_req, busy, done;
    logic [7:0] wr_addr, wr_data;

    always #10 clk = ~clk;

    pwrseq_ctrl #(.RST_CYC(RC), .LOCK_CYC(LC), .AW(8), .DW(8)) i_pwrseq_ctrl (
        .clk(clk), .rst_n(rst_n), .up_req(up_req), .down_req(down_req),
        .fx_sel(fx_sel), .wr_ack(wr_ack), .pdn_o(pdn_o), .wr_req(wr_req),
        .wr_addr(wr_addr), .wr_data(wr_data), .busy(busy), .done(done)
    );

    int checks = 0, errors = 0;
    bit finished = 0;

    // reference model: a queue of pending actions
    typedef struct {int kind; int n; int a; int d; int p;} op_t;
    localparam int K_DLY = 0, K_WR = 1, K_RDY = 2, K_OFF = 3;
    op_t q[$];
    int  m_mode = 0;   // 0 idle, 1 running, 2 ready
    int  m_cnt = 0;
    int  m_fx = 0;
    int  e_pdn = 0, e_req = 0, e_addr = 0, e_data = 0;
    int  ack_lat = 0, ack_cnt = 0;
    int  log_a[$], log_d[$];

    function automatic op_t mk(int k, int n, int a, int d, int p);
        op_t o; o.kind = k; o.n = n; o.a = a; o.d = d; o.p = p; return o;
    endfunction

    task automatic enter_head();
        op_t o = q[0];
        e_pdn = o.p;
        e_req = (o.kind == K_WR);
        e_addr = (o.kind == K_WR) ? o.a : 0;
        e_data = (o.kind == K_WR) ? o.d : 0;
        if (o.kind == K_DLY) m_cnt = o.n;
        if (o.kind == K_RDY) begin m_mode = 2; void'(q.pop_front()); end
        if (o.kind == K_OFF) begin m_mode = 0; void'(q.pop_front()); end
    endtask

    task automatic model_edge(bit up, bit dn, bit fx, bit ack);
        if (m_mode == 0) begin
            if (up) begin
                m_fx = fx;
                q.push_back(mk(K_DLY, RC, 0, 0, 0));
                q.push_back(mk(K_WR, 0, 'h10, 'h0F, 1));
                q.push_back(mk(K_DLY, LC, 0, 0, 1));
                q.push_back(mk(K_WR, 0, 'h11, 'h03, 1));
                if (m_fx != 0) q.push_back(mk(K_WR, 0, 'h12, 'h01, 1));
                q.push_back(mk(K_WR, 0, 'h13, 'h01, 1));
                q.push_back(mk(K_RDY, 0, 0, 0, 1));
                m_mode = 1;
                enter_head();
            end
        end else if (m_mode == 2) begin
            if (dn) begin
                q.push_back(mk(K_WR, 0, 'h13, 0, 1));
                if (m_fx != 0) q.push_back(mk(K_WR, 0, 'h12, 0, 1));
                q.push_back(mk(K_WR, 0, 'h11, 0, 1));
                q.push_back(mk(K_WR, 0, 'h10, 0, 1));
                q.push_back(mk(K_OFF, 0, 0, 0, 0));
                m_mode = 1;
                enter_head();
            end
        end else begin
            if (q[0].kind == K_DLY) begin
                if (m_cnt == 0) begin void'(q.pop_front()); enter_head(); end
                else m_cnt--;
            end else if (ack) begin
                void'(q.pop_front()); enter_head();
            end
        end
    endtask

    task automatic model_reset();
        q.delete(); m_mode = 0; m_cnt = 0; m_fx = 0;
        e_pdn = 0; e_req = 0; e_addr = 0; e_data = 0;
    endtask

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic string addr_tag(int a, int d);
        if (a == 'h10 && d != 0) return "R3 addr/data";
        if (a == 'h11 && d != 0) return "R4 addr/data";
        if (a == 'h12 && d != 0) return "R5 addr/data";
        if (a == 'h13 && d != 0) return "R6 addr/data";
        return "R8 addr/data";
    endfunction

    task automatic compare();
        check("R2 pdn_o", pdn_o, e_pdn);
        check("R7 wr_req", wr_req, e_req);
        if (e_req != 0) begin
            check(addr_tag(e_addr, e_data), wr_addr, e_addr);
            check(addr_tag(e_addr, e_data), wr_data, e_data);
        end
        check("R2 busy", busy, (m_mode == 1) ? 1 : 0);
        check("R6 done", done, (m_mode == 2) ? 1 : 0);
        check("R10 busy/done exclusive", busy & done, 0);
        check("R10 write only with pdn high", wr_req & ~pdn_o, 0);
    endtask

    task automatic step(bit up, bit dn);
        logic r; logic [7:0] a, d;
        up_req = up; down_req = dn;
        if (wr_req) begin
            if (ack_cnt == ack_lat) begin wr_ack = 1'b1; ack_cnt = 0; end
            else begin wr_ack = 1'b0; ack_cnt++; end
        end else begin
            wr_ack = 1'b0; ack_cnt = 0;
        end
        r = wr_req; a = wr_addr; d = wr_data;
        @(posedge clk);
        if (r && wr_ack) begin log_a.push_back(a); log_d.push_back(d); end
        model_edge(up, dn, fx_sel, wr_ack);
        @(negedge clk);
        compare();
        up_req = 1'b0; down_req = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; wr_ack = 1'b0; up_req = 1'b0; down_req = 1'b0;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 pdn_o after reset", pdn_o, 0);
        check("R1 wr_req after reset", wr_req, 0);
        check("R1 busy after reset", busy, 0);
        check("R1 done after reset", done, 0);
    endtask

    task automatic check_log(string tag, int ea[$], int ed[$]);
        check({tag, " write count"}, log_a.size(), ea.size());
        foreach (ea[i]) begin
            if (i < log_a.size()) begin
                check({tag, " write addr"}, log_a[i], ea[i]);
                check({tag, " write data"}, log_d[i], ed[i]);
            end
        end
        log_a.delete(); log_d.delete();
    endtask

    task automatic run_until_done(int limit);
        for (int i = 0; i < limit && !done; i++) step(0, 0);
    endtask

    task automatic run_until_idle(int limit);
        for (int i = 0; i < limit && (busy || done); i++) step(0, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog R7 actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        do_reset();
        for (int i = 0; i < 4; i++) step(0, 1);          // R9: down while idle ignored
        check("R9 down_req while idle", busy, 0);

        // power-up without effect, immediate ack; down_req mid-lock ignored (R9)
        fx_sel = 1'b0; ack_lat = 0; log_a.delete(); log_d.delete();
        step(1, 0);
        for (int i = 0; i < RC + 6; i++) step(0, 0);
        step(0, 1);
        fx_sel = 1'b1;                                  // R5: change after accept ignored
        run_until_done(500);
        check_log("R5 up no effect", '{'h10, 'h11, 'h13}, '{'h0F, 'h03, 'h01});
        for (int i = 0; i < 3; i++) step(1, 0);          // R9: up while ready ignored
        check("R9 up_req while ready", done, 1);

        // power-down without effect
        step(0, 1);
        run_until_idle(500);
        check_log("R8 down no effect", '{'h13, 'h11, 'h10}, '{0, 0, 0});
        check("R8 pdn_o after down", pdn_o, 0);

        // reset during the lock wait
        fx_sel = 1'b1; ack_lat = 1;
        step(1, 0);
        for (int i = 0; i < RC + 12; i++) step(0, 0);
        do_reset();
        log_a.delete(); log_d.delete();

        // power-up with effect, slow ack, fx_sel toggled afterwards
        fx_sel = 1'b1; ack_lat = 2;
        step(1, 0);
        fx_sel = 1'b0;
        run_until_done(800);
        check_log("R5 up with effect", '{'h10, 'h11, 'h12, 'h13}, '{'h0F, 'h03, 'h01, 'h01});
        step(0, 1);
        run_until_idle(800);
        check_log("R8 down with effect", '{'h13, 'h12, 'h11, 'h10}, '{0, 0, 0, 0});

        // back-to-back: up again right away with ack latency 1
        fx_sel = 1'b0; ack_lat = 1;
        step(1, 0);
        run_until_done(800);
        check_log("R6 second up", '{'h10, 'h11, 'h13}, '{'h0F, 'h03, 'h01});
        step(0, 1);
        run_until_idle(800);
        log_a.delete(); log_d.delete();

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule